// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small byte-wide configuration register file that a processor reaches through a pair of I/O ports: one port latches an index, the next port reads or writes the register the index selects. It sits on an 8-bit I/O bus and claims four consecutive port addresses starting at `BASE_ADDR`. Offset 0 is the index latch, offset 1 is the data window, offset 2 is decoded but does nothing, and a read at offset 3 raises a one-cycle soft-reset request toward the processor.

The register array has 256 byte entries, but only two sparse index ranges accept data traffic. A few bits in specific registers are protected from writes, and one of those protections depends on the chip identity byte held in entry 0. The whole array is exported as a flat bus so that memory, shadowing and timing decoders elsewhere in the chip can read their fields directly.

Top module: `cfg_port_regs`

## Requirements
- R1: After reset the index latch is 0x00; entry 0x00 holds `CHIP_ID`, entry 0x01 is 0xFF, 0x02 is 0x8A, 0x03 is 0x88, 0x06 is 0x1B, 0x08 is 0x38, entry 0x07 is 0x21 when `CHIP_ID` is 0x98 and 0x00 otherwise, and every other entry is 0x00.
- R2: A write at offset 0 loads the index latch from `io_wdata` on that clock edge; a read at offset 0 returns the latch value.
- R3: With the index in 0x01..0x19 or 0x20..0x24, a read at offset 1 returns the selected entry and a write at offset 1 stores `io_wdata` into it, subject to R5..R7.
- R4: With the index anywhere else (including 0x00, 0x1A..0x1F and 0x25..0xFF), a read at offset 1 returns 0xFF and a write at offset 1 changes no entry.
- R5: A write to entry 0x05 leaves its bit 4 unchanged; the other seven bits take the written value.
- R6: A write to entry 0x07 leaves its bit 6 unchanged; the other seven bits take the written value.
- R7: A write to entry 0x04 leaves bit 3 unchanged when `CHIP_ID` is 0x98; for any other identity all eight bits are written.
- R8: A read at offset 3 returns 0xFF and makes `soft_rst_o` high for exactly the one cycle following the read strobe; `soft_rst_o` is low otherwise.
- R9: A read at offset 2 returns 0xFF, and a write at offset 2 changes neither the index latch nor any entry.
- R10: Addresses outside the four decoded ports read as 0xFF and writes to them change neither the index latch nor any entry.
- R11: `reg_bus_o` bits [8*k+7:8*k] show entry k; a data write becomes visible there after the clock edge that samples the write strobe and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and current state |
| soft_rst_o | output | 1 | One-cycle soft-reset request |
| reg_bus_o | output | 2048 | All 256 entries, entry k at bits [8k+7:8k] |

## Verification
Read data is combinational, so the bench drives each strobe just after a falling edge and samples `io_rdata` two nanoseconds later in the same cycle. Index and register writes land on the following rising edge: the bench checks the exported entry is still old just before that edge and new at the next falling edge. The soft-reset request is registered, so it is checked high at the falling edge one cycle after the read strobe and low at the falling edge after that. Two instances with identities 0x98 and 0x90 receive the same sweep over all 256 index values.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int unsigned DW   = 8;
    localparam int unsigned NREG = 1 << DW;

    localparam logic [7:0] WIN_A_LO = 8'h01;
    localparam logic [7:0] WIN_A_HI = 8'h19;
    localparam logic [7:0] WIN_B_LO = 8'h20;
    localparam logic [7:0] WIN_B_HI = 8'h24;

    localparam logic [7:0] ID_GUARDS_R4 = 8'h98;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_INDEX,
        PORT_DATA,
        PORT_SPARE,
        PORT_SRST
    } port_sel_t;

    function automatic logic in_window(input logic [7:0] i);
        return ((i >= WIN_A_LO) && (i <= WIN_A_HI)) ||
               ((i >= WIN_B_LO) && (i <= WIN_B_HI));
    endfunction

    // Bits of an entry that a data write must leave alone.
    function automatic logic [7:0] keep_mask(input logic [7:0] id,
                                             input logic [7:0] i);
        logic [7:0] m;
        case (i)
            8'h04:   m = (id == ID_GUARDS_R4) ? 8'h08 : 8'h00;
            8'h05:   m = 8'h10;
            8'h07:   m = 8'h40;
            default: m = 8'h00;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] id,
                                               input logic [7:0] i);
        logic [7:0] v;
        case (i)
            8'h00:   v = id;
            8'h01:   v = 8'hFF;
            8'h02:   v = 8'h8A;
            8'h03:   v = 8'h88;
            8'h06:   v = 8'h1B;
            8'h07:   v = (id == ID_GUARDS_R4) ? 8'h21 : 8'h00;
            8'h08:   v = 8'h38;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 16,
    parameter logic [15:0]     BASE_ADDR = 16'h00EC
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_t         sel
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off = addr - BASE;
        sel = PORT_NONE;
        if (off < ADDR_W'(4)) begin
            case (off[1:0])
                2'd0:    sel = PORT_INDEX;
                2'd1:    sel = PORT_DATA;
                2'd2:    sel = PORT_SPARE;
                default: sel = PORT_SRST;
            endcase
        end
    end
endmodule

// File: rtl/cfg_port_merge.sv
module cfg_port_merge
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h90
) (
    input  logic [7:0] idx,
    input  logic [7:0] old_val,
    input  logic [7:0] wdata,
    output logic       hit,
    output logic [7:0] new_val
);
    logic [7:0] km;

    always_comb begin
        hit     = in_window(idx);
        km      = keep_mask(CHIP_ID, idx);
        new_val = (old_val & km) | (wdata & ~km);
    end
endmodule

// File: rtl/cfg_port_regfile.sv
module cfg_port_regfile
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h90
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [7:0]                idx,
    input  logic [7:0]                wdata,
    output logic [NREG-1:0][DW-1:0]   regs
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t                s_d, s_q;
    logic [NREG-1:0][DW-1:0]  rst_vals;
    logic                     hit;
    logic [7:0]               merged;

    for (genvar g = 0; g < NREG; g++) begin : g_rst
        assign rst_vals[g] = reset_value(CHIP_ID, 8'(g));
    end

    cfg_port_merge #(.CHIP_ID(CHIP_ID)) u_merge (
        .idx     (idx),
        .old_val (s_q.regs[idx]),
        .wdata   (wdata),
        .hit     (hit),
        .new_val (merged)
    );

    always_comb begin
        s_d = s_q;
        if (we && hit) begin
            s_d.regs[idx] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.regs <= rst_vals;
        end else begin
            s_q <= s_d;
        end
    end

    assign regs = s_q.regs;

    // R4: writes outside both windows leave every entry alone
    a_r4_outside_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_window(idx)) |=> $stable(s_q.regs));

    // R5: entry 0x05 bit 4 survives a write
    a_r5_bit4_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == 8'h05) |=> (s_q.regs[5][4] == $past(s_q.regs[5][4])));

    // R6: entry 0x07 bit 6 survives a write
    a_r6_bit6_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == 8'h07) |=> (s_q.regs[7][6] == $past(s_q.regs[7][6])));

    // R7: entry 0x04 bit 3 survives only for the guarding identity
    a_r7_bit3_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == 8'h04) |=>
            (s_q.regs[4][3] == ((CHIP_ID == ID_GUARDS_R4) ?
                                $past(s_q.regs[4][3]) : $past(wdata[3]))));

    // R3: an unguarded in-window write lands whole
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_window(idx) && idx != 8'h04 && idx != 8'h05 && idx != 8'h07)
            |=> (s_q.regs[$past(idx)] == $past(wdata)));

    // R1: the identity entry never changes
    a_r1_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.regs[0] == CHIP_ID);
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
    import cfg_port_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h00EC,
    parameter logic [7:0]  CHIP_ID   = 8'h90
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  soft_rst_o,
    output logic [NREG*DW-1:0]    reg_bus_o
);
    typedef struct packed {
        logic [7:0] idx;
        logic       srst;
    } top_state_t;

    top_state_t               s_d, s_q;
    port_sel_t                sel;
    logic [NREG-1:0][DW-1:0]  regs;
    logic                     data_we;

    cfg_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (io_addr),
        .sel  (sel)
    );

    assign data_we = io_wr && (sel == PORT_DATA);

    cfg_port_regfile #(.CHIP_ID(CHIP_ID)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (data_we),
        .idx   (s_q.idx),
        .wdata (io_wdata),
        .regs  (regs)
    );

    always_comb begin
        s_d      = s_q;
        s_d.srst = io_rd && (sel == PORT_SRST);
        if (io_wr && (sel == PORT_INDEX)) begin
            s_d.idx = io_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        io_rdata = 8'hFF;
        case (sel)
            PORT_INDEX: io_rdata = s_q.idx;
            PORT_DATA:  io_rdata = in_window(s_q.idx) ? regs[s_q.idx] : 8'hFF;
            default:    io_rdata = 8'hFF;
        endcase
    end

    assign soft_rst_o = s_q.srst;
    assign reg_bus_o  = regs;

    // R2: an index write is visible the next cycle
    a_r2_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel == PORT_INDEX) |=> (s_q.idx == $past(io_wdata)));

    // R8: a read at offset 3 raises the request next cycle
    a_r8_srst_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && sel == PORT_SRST) |=> soft_rst_o);

    // R8: the request is never raised without that read
    a_r8_srst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(io_rd && sel == PORT_SRST));

    // R9, R10: writes elsewhere leave the index alone
    a_r9_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (sel == PORT_SPARE || sel == PORT_NONE)) |=> $stable(s_q.idx));
endmodule

// File: tb/cfg_port_regs_tb.sv
module cfg_port_regs_tb;
    localparam logic [15:0] BASE = 16'h00EC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   addr = 16'h0000;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [7:0]    wdat = 8'h00;
    logic [7:0]    rdata98, rdata90;
    logic          srst98, srst90;
    logic [2047:0] bus98, bus90;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp98 [256];
    logic [7:0] exp90 [256];
    logic [7:0] cur_idx;

    always #5 clk = ~clk;

    cfg_port_regs #(.BASE_ADDR(BASE), .CHIP_ID(8'h98)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(addr), .io_rd(rd), .io_wr(wr),
        .io_wdata(wdat), .io_rdata(rdata98), .soft_rst_o(srst98), .reg_bus_o(bus98));

    cfg_port_regs #(.BASE_ADDR(BASE), .CHIP_ID(8'h90)) u_dut90 (
        .clk(clk), .rst_n(rst_n), .io_addr(addr), .io_rd(rd), .io_wr(wr),
        .io_wdata(wdat), .io_rdata(rdata90), .soft_rst_o(srst90), .reg_bus_o(bus90));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic win(input int i);
        return (i >= 8'h01 && i <= 8'h19) || (i >= 8'h20 && i <= 8'h24);
    endfunction

    function automatic logic [7:0] rval(input logic [7:0] id, input int i);
        case (i)
            0: return id;
            1: return 8'hFF;
            2: return 8'h8A;
            3: return 8'h88;
            6: return 8'h1B;
            7: return (id == 8'h98) ? 8'h21 : 8'h00;
            8: return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] kmask(input logic [7:0] id, input int i);
        if (i == 4) return (id == 8'h98) ? 8'h08 : 8'h00;
        if (i == 5) return 8'h10;
        if (i == 7) return 8'h40;
        return 8'h00;
    endfunction

    function automatic string tag_for(input int i);
        if (i == 4) return "R7";
        if (i == 5) return "R5";
        if (i == 7) return "R6";
        if (win(i)) return "R3";
        return "R4";
    endfunction

    task automatic check_all_bus(input string tag);
        for (int k = 0; k < 256; k++) begin
            chk(tag, bus98[k*8 +: 8], exp98[k]);
            chk(tag, bus90[k*8 +: 8], exp90[k]);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdat = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 16'h0000;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] r98, output logic [7:0] r90);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2;
        r98 = rdata98; r90 = rdata90;
        @(negedge clk);
        rd = 1'b0; addr = 16'h0000;
    endtask

    // Data write with model update; R11 timing checked around the edge.
    task automatic data_wr(input logic [7:0] d);
        int i;
        logic [7:0] o98, o90;
        i = int'(cur_idx);
        @(negedge clk);
        addr = BASE + 16'd1; wdat = d; wr = 1'b1;
        #2;
        chk("R11 before edge", bus98[i*8 +: 8], exp98[i]);
        o98 = exp98[i]; o90 = exp90[i];
        if (win(i)) begin
            exp98[i] = (o98 & kmask(8'h98, i)) | (d & ~kmask(8'h98, i));
            exp90[i] = (o90 & kmask(8'h90, i)) | (d & ~kmask(8'h90, i));
        end
        @(negedge clk);
        wr = 1'b0; addr = 16'h0000;
        chk({tag_for(i), " R11 after edge"}, bus98[i*8 +: 8], exp98[i]);
        chk({tag_for(i), " R11 after edge"}, bus90[i*8 +: 8], exp90[i]);
    endtask

    task automatic check_data_rd(input int i);
        logic [7:0] r98, r90;
        bus_rd(BASE + 16'd1, r98, r90);
        chk(tag_for(i), r98, win(i) ? exp98[i] : 8'hFF);
        chk(tag_for(i), r90, win(i) ? exp90[i] : 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] r98, r90, p;
        for (int k = 0; k < 256; k++) begin
            exp98[k] = rval(8'h98, k);
            exp90[k] = rval(8'h90, k);
        end
        cur_idx = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_rd(BASE, r98, r90);
        chk("R1 index", r98, 8'h00);
        chk("R1 index", r90, 8'h00);
        check_all_bus("R1 reset entries");
        chk("R8 idle", {7'd0, srst98}, 8'h00);

        // Full index sweep: R2, R3, R4, R5, R6, R7, R11
        for (int i = 0; i < 256; i++) begin
            bus_wr(BASE, 8'(i));
            cur_idx = 8'(i);
            bus_rd(BASE, r98, r90);
            chk("R2 index readback", r98, 8'(i));
            chk("R2 index readback", r90, 8'(i));
            check_data_rd(i);
            p = 8'((i * 37 + 91) & 8'hFF);
            data_wr(p);
            check_data_rd(i);
            data_wr(~p);
            check_data_rd(i);
            data_wr(8'hFF);
            data_wr(8'h00);
            check_data_rd(i);
        end
        check_all_bus("R4 sweep untouched entries");

        // R9: spare port
        bus_wr(BASE, 8'h02);
        cur_idx = 8'h02;
        bus_wr(BASE + 16'd2, 8'h5A);
        bus_rd(BASE + 16'd2, r98, r90);
        chk("R9 spare read", r98, 8'hFF);
        chk("R9 spare read", r90, 8'hFF);
        bus_rd(BASE, r98, r90);
        chk("R9 index kept", r98, 8'h02);
        check_all_bus("R9 entries kept");

        // R10: addresses outside the decoded range
        bus_wr(BASE - 16'd1, 8'h33);
        bus_wr(BASE + 16'd4, 8'h34);
        bus_wr(16'h10EC, 8'h35);
        bus_wr(16'h10ED, 8'h36);
        bus_rd(BASE - 16'd1, r98, r90);
        chk("R10 below read", r98, 8'hFF);
        bus_rd(BASE + 16'd4, r98, r90);
        chk("R10 above read", r90, 8'hFF);
        bus_rd(16'h10EC, r98, r90);
        chk("R10 alias read", r98, 8'hFF);
        bus_rd(BASE, r98, r90);
        chk("R10 index kept", r98, 8'h02);
        chk("R10 index kept", r90, 8'h02);
        check_all_bus("R10 entries kept");
        chk("R8 idle after other reads", {7'd0, srst98 | srst90}, 8'h00);

        // R8: soft-reset pulse
        for (int n = 0; n < 3; n++) begin
            bus_rd(BASE + 16'd3, r98, r90);
            chk("R8 read value", r98, 8'hFF);
            chk("R8 read value", r90, 8'hFF);
            chk("R8 pulse high", {7'd0, srst98}, 8'h01);
            chk("R8 pulse high", {7'd0, srst90}, 8'h01);
            @(negedge clk);
            chk("R8 pulse low", {7'd0, srst98}, 8'h00);
            chk("R8 pulse low", {7'd0, srst90}, 8'h00);
        end
        bus_wr(BASE + 16'd3, 8'h77);
        @(negedge clk);
        chk("R8 write no pulse", {7'd0, srst98}, 8'h00);
        check_all_bus("R8 entries kept");

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule